// File: doc/BRIEF.md
# Serial Audio Word Capture Receiver

This block receives a two-channel serial audio stream from an external converter and turns it into parallel 24-bit signed PCM words. The bit clock, the word-select clock and the serial data are all sampled in the local system clock domain. Each input passes through a synchronizer, and the rising edges of the bit clock are detected from the synchronized copy. A slot counter then walks through each word-select half-period. The first bit-clock rise after a word-select change carries no data. The next 24 rises carry the sample, most significant bit first. Any further rises in that half-period are skipped.

Each finished word appears on a parallel output together with a channel flag, marked by a one-cycle valid strobe. The word and the flag then stay unchanged until the next word arrives. A word that is cut short by an early word-select change is dropped. After reset, the block stays idle until it sees its first word-select change. Several instances can sit side by side, one per converter. The system clock must run at least four times as fast as the bit clock.

Top module: `i2s_rx_capture`

## Requirements
- R1: While reset is held and right after it is released, sample_valid, is_right and sample_data are all zero.
- R2: A word received while lrclk_in is low is reported with is_right = 0 (left). A word received while lrclk_in is high is reported with is_right = 1 (right).
- R3: The first rising edge of bclk_in after an lrclk_in transition is ignored. The bit present on the second rising edge becomes sample_data[23].
- R4: The 23 rising bclk_in edges that follow the most significant bit fill sample_data[22] down to sample_data[0], in that order.
- R5: Rising bclk_in edges after the 24th data bit, up to the end of a 32-slot half-period, change neither the word nor the strobe.
- R6: sample_valid is high for exactly one system clock cycle per word. That cycle begins on the third rising system clock edge after the bclk_in rise that carries sample_data[0].
- R7: When sample_valid is low, sample_data and is_right keep the values they had on the last strobe.
- R8: If lrclk_in changes before all 24 data bits of a half-period have arrived, that partial word is discarded and no strobe is issued for it.
- R9: After reset, no word is output until the first lrclk_in transition seen after reset. This holds even if a full half-period of bits arrives before it.
- R10: Capture is correct with a bit clock period of four system clock cycles, and also with slower bit clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_in | input | 1 | External serial bit clock, asynchronous |
| lrclk_in | input | 1 | External word-select clock, low = left, high = right |
| sdata_in | input | 1 | External serial data, stable around bclk_in rises |
| sample_data | output | 24 | Most recent complete word, two's complement |
| is_right | output | 1 | Channel of sample_data, 1 = right |
| sample_valid | output | 1 | One-cycle strobe marking a new word |

## Verification
A word is due three system clock cycles after the bclk_in rise that carries its last bit. That is two synchronizer stages plus the output register. The bench records the cycle count at which it raised that bit-clock edge, and a monitor records the cycle of every strobe. The bench then requires the difference to be exactly three. Word contents and channel flags are compared only after the driving task has finished its whole half-period, which is long after the strobe is due. Between strobes, the monitor samples the outputs on every falling system clock edge to confirm that the word and flag are held and that no strobe lasts two cycles.

// File: rtl/i2s_cap_pkg.sv
package i2s_cap_pkg;

  // Default geometry of one half-frame
  localparam int unsigned DEF_SAMPLE_W = 24;
  localparam int unsigned DEF_SLOTS    = 32;
  localparam int unsigned DEF_SKIP     = 1;
  localparam int unsigned DEF_SYNC     = 2;

  // Where the framer stands inside the current half-frame
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,  // no word-select change seen since reset
    PH_SKIP = 2'd1,  // dead slot(s) after the change
    PH_DATA = 2'd2,  // data bits being collected
    PH_TAIL = 2'd3   // padding slots, ignored
  } frame_phase_e;

  // Rise index (0-based since the word-select change) carrying the LSB
  function automatic int unsigned last_data_slot(input int unsigned skip,
                                                 input int unsigned width);
    return skip + width - 1;
  endfunction

endpackage

// File: rtl/i2s_cap_sync.sv
module i2s_cap_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  generate
    if (STAGES <= 1) begin : g_single
      logic [WIDTH-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= din;
      end
      assign dout = q;
    end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] chain;
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], din};
      end
      assign dout = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/i2s_cap_edge.sv
module i2s_cap_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_s,
  input  logic lrclk_s,
  input  logic sdata_s,
  output logic bclk_rise,
  output logic ws_edge,
  output logic ws_level,
  output logic data_bit
);

  localparam int unsigned FILL_W = $clog2(SYNC_STAGES + 1);

  logic [FILL_W-1:0] fill_cnt;
  logic              primed;
  logic              bclk_prev;
  logic              ws_prev;

  // Edges are reported only once the synchronizer holds real input,
  // so reset values never look like a transition.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_cnt  <= '0;
      primed    <= 1'b0;
      bclk_prev <= 1'b0;
      ws_prev   <= 1'b0;
    end else begin
      if (fill_cnt != FILL_W'(SYNC_STAGES)) fill_cnt <= fill_cnt + 1'b1;
      primed    <= (fill_cnt == FILL_W'(SYNC_STAGES));
      bclk_prev <= bclk_s;
      ws_prev   <= lrclk_s;
    end
  end

  assign bclk_rise = primed && bclk_s && !bclk_prev;
  assign ws_edge   = primed && (lrclk_s != ws_prev);
  assign ws_level  = lrclk_s;
  assign data_bit  = sdata_s;

endmodule

// File: rtl/i2s_cap_framer.sv
module i2s_cap_framer
  import i2s_cap_pkg::*;
#(
  parameter int unsigned SAMPLE_W       = DEF_SAMPLE_W,
  parameter int unsigned SLOTS_PER_HALF = DEF_SLOTS,
  parameter int unsigned SKIP_SLOTS     = DEF_SKIP,
  parameter int unsigned CNT_W          = $clog2(SLOTS_PER_HALF + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk_rise,
  input  logic                ws_edge,
  input  logic                ws_level,
  input  logic                data_bit,
  output logic                armed,
  output logic [CNT_W-1:0]    slot_idx,
  output frame_phase_e        phase,
  output logic                word_done,
  output logic [SAMPLE_W-1:0] word_out,
  output logic                word_right
);

  localparam int unsigned LAST_SLOT = last_data_slot(SKIP_SLOTS, SAMPLE_W);

  logic [SAMPLE_W-1:0] shreg;
  logic [CNT_W-1:0]    cnt;
  logic                chan;

  function automatic logic [SAMPLE_W-1:0] push_bit(input logic [SAMPLE_W-1:0] acc,
                                                   input logic b);
    return {acc[SAMPLE_W-2:0], b};
  endfunction

  always_comb begin
    if (!armed)                                   phase = PH_IDLE;
    else if (cnt < CNT_W'(SKIP_SLOTS))            phase = PH_SKIP;
    else if (cnt < CNT_W'(SKIP_SLOTS + SAMPLE_W)) phase = PH_DATA;
    else                                          phase = PH_TAIL;
  end

  // A word-select change restarts the half-frame. A rise in the same
  // cycle counts as the first (dead) slot of the new half-frame.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt   <= '0;
      chan  <= 1'b0;
      shreg <= '0;
    end else if (ws_edge) begin
      armed <= 1'b1;
      chan  <= ws_level;
      cnt   <= bclk_rise ? CNT_W'(1) : '0;
      shreg <= '0;
    end else if (bclk_rise && armed) begin
      if (cnt != CNT_W'(SLOTS_PER_HALF)) cnt <= cnt + 1'b1;
      if (phase == PH_DATA) shreg <= push_bit(shreg, data_bit);
    end
  end

  assign slot_idx   = cnt;
  assign word_done  = bclk_rise && !ws_edge && (phase == PH_DATA) &&
                      (cnt == CNT_W'(LAST_SLOT));
  assign word_out   = push_bit(shreg, data_bit);
  assign word_right = chan;

endmodule

// File: rtl/i2s_rx_capture.sv
module i2s_rx_capture
  import i2s_cap_pkg::*;
#(
  parameter int unsigned SAMPLE_W       = DEF_SAMPLE_W,
  parameter int unsigned SLOTS_PER_HALF = DEF_SLOTS,
  parameter int unsigned SKIP_SLOTS     = DEF_SKIP,
  parameter int unsigned SYNC_STAGES    = DEF_SYNC
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk_in,
  input  logic                lrclk_in,
  input  logic                sdata_in,
  output logic [SAMPLE_W-1:0] sample_data,
  output logic                is_right,
  output logic                sample_valid
);

  localparam int unsigned CNT_W = $clog2(SLOTS_PER_HALF + 1);

  logic [2:0]          pins_s;
  logic                bclk_rise;
  logic                ws_edge;
  logic                ws_level;
  logic                data_bit;
  logic                armed;
  logic [CNT_W-1:0]    slot_idx;
  frame_phase_e        phase;
  logic                word_done;
  logic [SAMPLE_W-1:0] word_out;
  logic                word_right;

  i2s_cap_sync #(
    .WIDTH (3),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({bclk_in, lrclk_in, sdata_in}),
    .dout (pins_s)
  );

  i2s_cap_edge #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .bclk_s   (pins_s[2]),
    .lrclk_s  (pins_s[1]),
    .sdata_s  (pins_s[0]),
    .bclk_rise(bclk_rise),
    .ws_edge  (ws_edge),
    .ws_level (ws_level),
    .data_bit (data_bit)
  );

  i2s_cap_framer #(
    .SAMPLE_W      (SAMPLE_W),
    .SLOTS_PER_HALF(SLOTS_PER_HALF),
    .SKIP_SLOTS    (SKIP_SLOTS),
    .CNT_W         (CNT_W)
  ) u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .bclk_rise (bclk_rise),
    .ws_edge   (ws_edge),
    .ws_level  (ws_level),
    .data_bit  (data_bit),
    .armed     (armed),
    .slot_idx  (slot_idx),
    .phase     (phase),
    .word_done (word_done),
    .word_out  (word_out),
    .word_right(word_right)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sample_valid <= 1'b0;
      sample_data  <= '0;
      is_right     <= 1'b0;
    end else begin
      sample_valid <= word_done;
      if (word_done) begin
        sample_data <= word_out;
        is_right    <= word_right;
      end
    end
  end

endmodule

// File: rtl/i2s_rx_capture_chk.sv
module i2s_rx_capture_chk #(
  parameter int unsigned SAMPLE_W  = 24,
  parameter int unsigned CNT_W     = 6,
  parameter int unsigned LAST_SLOT = 24
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bclk_rise,
  input logic                ws_edge,
  input logic                ws_level,
  input logic                armed,
  input logic [CNT_W-1:0]    slot_idx,
  input logic                sample_valid,
  input logic [SAMPLE_W-1:0] sample_data,
  input logic                is_right
);

  // R2: the flag reflects the word-select level of the finished half-frame
  assert_side_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> (is_right == $past(ws_level)));

  // R3: the strobe follows the rise at the last data slot index,
  // which is reached only after the dead slot was skipped
  assert_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> ($past(slot_idx) == CNT_W'(LAST_SLOT)));

  // R4: every word is completed by a bit-clock rise
  assert_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> $past(bclk_rise));

  // R6: single-cycle strobe
  assert_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid);

  // R7: outputs held between strobes
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |-> ($stable(sample_data) && $stable(is_right)));

  // R8: a word-select change never completes a word
  assert_no_cross_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> !$past(ws_edge));

  // R9: nothing is emitted before the first word-select change
  assert_startup_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !sample_valid);

endmodule

bind i2s_rx_capture i2s_rx_capture_chk #(
  .SAMPLE_W (SAMPLE_W),
  .CNT_W    (CNT_W),
  .LAST_SLOT(SKIP_SLOTS + SAMPLE_W - 1)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bclk_rise   (bclk_rise),
  .ws_edge     (ws_edge),
  .ws_level    (ws_level),
  .armed       (armed),
  .slot_idx    (slot_idx),
  .sample_valid(sample_valid),
  .sample_data (sample_data),
  .is_right    (is_right)
);

// File: tb/i2s_rx_capture_test.sv
module i2s_rx_capture_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b0;
  logic        lrclk = 1'b1;
  logic        sdata = 1'b0;
  logic [23:0] sample_data;
  logic        is_right;
  logic        sample_valid;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int rise24_cyc = 0;
  bit done = 1'b0;

  int          ncap = 0;
  logic [23:0] cap_d [64];
  logic        cap_r [64];
  int          cap_cyc [64];
  int          dbl_err = 0;
  int          hold_err = 0;
  logic        prev_v = 1'b0;
  logic [23:0] last_d = '0;
  logic        last_r = 1'b0;

  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  i2s_rx_capture uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .bclk_in     (bclk),
    .lrclk_in    (lrclk),
    .sdata_in    (sdata),
    .sample_data (sample_data),
    .is_right    (is_right),
    .sample_valid(sample_valid)
  );

  // Output monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (sample_valid) begin
        if (ncap < 64) begin
          cap_d[ncap]   = sample_data;
          cap_r[ncap]   = is_right;
          cap_cyc[ncap] = cyc;
        end
        ncap = ncap + 1;
      end
      if (sample_valid && prev_v) dbl_err = dbl_err + 1;
      if (!sample_valid && ((sample_data != last_d) || (is_right != last_r)))
        hold_err = hold_err + 1;
      prev_v = sample_valid;
      last_d = sample_data;
      last_r = is_right;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_word(input int idx, input logic [23:0] d, input logic r,
                             input string req);
    if (idx >= ncap || idx >= 64) begin
      chk(1'b0, {req, " word missing"}, 32'(ncap), 32'(idx + 1));
    end else begin
      chk(cap_d[idx] == d, {req, " data"}, {8'h0, cap_d[idx]}, {8'h0, d});
      chk(cap_r[idx] == r, {req, " channel"}, {31'h0, cap_r[idx]}, {31'h0, r});
    end
  endtask

  // One half-frame of nslots bit slots, hp system cycles per bit-clock phase.
  // Slot 0 and slots past 24 carry the inverse of w[0] as junk.
  task automatic drive_half(input logic side, input logic [23:0] w,
                            input int nslots, input int hp);
    for (int i = 0; i < nslots; i++) begin
      @(negedge clk);
      bclk = 1'b0;
      if (i == 0) lrclk = side;
      sdata = (i >= 1 && i <= 24) ? w[24-i] : ~w[0];
      repeat (hp - 1) @(negedge clk);
      @(negedge clk);
      bclk = 1'b1;
      if (i == 24) rise24_cyc = cyc;
      repeat (hp - 1) @(negedge clk);
    end
  endtask

  task automatic t_reset;
    repeat (6) @(negedge clk);
    chk(sample_valid == 1'b0, "R1 valid in reset", {31'h0, sample_valid}, 32'h0);
    chk(sample_data == 24'h0, "R1 data in reset", {8'h0, sample_data}, 32'h0);
    chk(is_right == 1'b0, "R1 channel in reset", {31'h0, is_right}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sample_valid == 1'b0 && sample_data == 24'h0, "R1 after release",
        {7'h0, sample_valid, sample_data}, 32'h0);
  endtask

  task automatic t_startup;
    // lrclk already high through reset: no change seen, so nothing output
    drive_half(1'b1, 24'h123456, 32, 4);
    repeat (10) @(negedge clk);
    chk(ncap == 0, "R9 no word before first change", 32'(ncap), 32'h0);
    drive_half(1'b0, 24'hA5C33C, 32, 4);
    repeat (10) @(negedge clk);
    chk(ncap == 1, "R9 word after first change", 32'(ncap), 32'h1);
    expect_word(0, 24'hA5C33C, 1'b0, "R2 R4 first left word");
  endtask

  task automatic t_stereo;
    int base = ncap;
    drive_half(1'b1, 24'h800000, 32, 4);
    drive_half(1'b0, 24'h7FFFFF, 32, 4);
    drive_half(1'b1, 24'h000000, 32, 4);
    drive_half(1'b0, 24'hFFFFFF, 32, 4);
    repeat (10) @(negedge clk);
    chk(ncap == base + 4, "R5 one word per half-frame", 32'(ncap), 32'(base + 4));
    expect_word(base + 0, 24'h800000, 1'b1, "R2 R3 right MSB only");
    expect_word(base + 1, 24'h7FFFFF, 1'b0, "R3 R4 left all but MSB");
    expect_word(base + 2, 24'h000000, 1'b1, "R3 R5 zero word with junk ones");
    expect_word(base + 3, 24'hFFFFFF, 1'b0, "R5 all ones with junk zeros");
    if (ncap == base + 4 && ncap <= 64)
      chk(cap_cyc[base + 3] - rise24_cyc == 3, "R6 strobe latency",
          32'(cap_cyc[base + 3] - rise24_cyc), 32'h3);
  endtask

  task automatic t_partial;
    int base = ncap;
    drive_half(1'b1, 24'h0F0F0F, 20, 4);
    drive_half(1'b0, 24'h13579B, 32, 4);
    drive_half(1'b1, 24'h2468AC, 24, 4);
    drive_half(1'b0, 24'hC0FFEE, 32, 4);
    repeat (10) @(negedge clk);
    chk(ncap == base + 2, "R8 short halves dropped", 32'(ncap), 32'(base + 2));
    expect_word(base + 0, 24'h13579B, 1'b0, "R8 word after short half");
    expect_word(base + 1, 24'hC0FFEE, 1'b0, "R8 word after 23-bit half");
  endtask

  task automatic t_ratio;
    int base = ncap;
    drive_half(1'b1, 24'h5A5A5A, 32, 2);
    drive_half(1'b0, 24'h963C81, 32, 2);
    drive_half(1'b1, 24'h3E1D07, 32, 7);
    repeat (10) @(negedge clk);
    chk(ncap == base + 3, "R10 word count", 32'(ncap), 32'(base + 3));
    expect_word(base + 0, 24'h5A5A5A, 1'b1, "R10 fastest bit clock right");
    expect_word(base + 1, 24'h963C81, 1'b0, "R10 fastest bit clock left");
    expect_word(base + 2, 24'h3E1D07, 1'b1, "R10 slow bit clock");
    if (ncap == base + 3 && ncap <= 64)
      chk(cap_cyc[base + 2] - rise24_cyc == 3, "R6 latency slow clock",
          32'(cap_cyc[base + 2] - rise24_cyc), 32'h3);
  endtask

  task automatic t_strobe_hold;
    chk(dbl_err == 0, "R6 strobe one cycle", 32'(dbl_err), 32'h0);
    chk(hold_err == 0, "R7 outputs held between strobes", 32'(hold_err), 32'h0);
  endtask

  initial begin
    t_reset();
    t_startup();
    t_stereo();
    t_partial();
    t_ratio();
    t_strobe_hold();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule